// File: doc/BRIEF.md
# PCI Base Address Register with Address Decoder

This block holds one base address register of a PCI target's configuration header and decodes bus addresses against it. Configuration software writes the register a byte lane at a time and reads it back. Address bits below the decode size are hardwired to zero, so writing all ones and reading back shows the region size. Fixed low bits report whether the region is memory or I/O space, the memory type, and the prefetchable flag. A memory register can be built as a 64-bit register that spans two consecutive dwords. In that case the upper dword holds address bits 63:32.

The hit output is combinational from the bus address. The device select logic uses it to claim a transaction. Decoding is gated only by the memory-space and I/O-space enable bits of the command register. A base of zero is a valid decode target and does not disable the register. Parameters select the space type, 64-bit layout, prefetchable flag, log2 of the region size and whether the register exists at all. A register that does not exist reads zero after any write and never hits.

Top module: `bar_decoder`

## Requirements
- R1: With IMPL=0 the register reads 0x00000000 for both dword selects after any write, and hit stays 0.
- R2: The effective size exponent is SIZE_LOG2 raised to a minimum of 4 for memory and 2 for I/O. Address bits below that exponent read as zero and ignore writes. After an all-ones write to the lower dword, the address field reads as all ones above the boundary.
- R3: A memory register reads bit 0 = 0, bits 2:1 = 00 when it is 32-bit or 10 when it is 64-bit, and bit 3 = PREFETCH.
- R4: An I/O register reads bit 0 = 1 and bit 1 = 0.
- R5: Reset clears every writable base bit, so after reset only the fixed type bits read as ones.
- R6: A configuration write changes only the byte lanes whose enable bit is set. Bit n of cfg_be covers data bits 8n+7:8n.
- R7: With cfg_hi_sel=1, a 64-bit memory register reads and writes address bits 63:32 with all 32 bits writable. Every other configuration reads 0 there, and writes there are ignored.
- R8: When the space enable is set, hit is 1 exactly when bus_addr[31:0] matches the base at and above the size boundary and the upper half condition holds. For a 64-bit register, bus_addr[63:32] must equal the upper dword. For a 32-bit memory register, bus_addr[63:32] must be zero. I/O ignores bus_addr[63:32].
- R9: A base of zero is decoded like any other base. With the enable set, an address inside the lowest region hits.
- R10: hit is 0 whenever the enable for the register's own space type is 0. The enable of the other space type has no effect.
- R11: A configuration write takes effect on the clock edge at which it is sampled. hit follows bus_addr and the enables with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_hi_sel | input | 1 | Dword select: 0 for the lower dword, 1 for the upper dword |
| cfg_be | input | 4 | Byte lane enables for a write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back value of the selected dword |
| bus_addr | input | 64 | Bus address being decoded |
| mem_en | input | 1 | Memory space enable from the command register |
| io_en | input | 1 | I/O space enable from the command register |
| hit | output | 1 | Address falls in this register's region |

## Verification
The bench targets the zero base right after reset. A design that treated zero as "disabled" would miss the hit at address 0. It probes the size boundary with all-ones writes and with addresses one bit outside the region. A wrong mask would widen or shrink the region and read back writable low bits. It writes partial byte enables, which expose a design that writes whole dwords. It drives mismatched upper halves against the 64-bit and 32-bit memory instances, and a design that ignored bus_addr[63:32] would then claim foreign addresses. It also toggles the wrong space's enable, which catches gating on the wrong command bit.

// File: rtl/bar_decoder.sv
module bar_decoder #(
  parameter bit IS_IO     = 1'b0,
  parameter bit IS_64     = 1'b0,
  parameter bit PREFETCH  = 1'b0,
  parameter int SIZE_LOG2 = 12,
  parameter bit IMPL      = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_hi_sel,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [63:0] bus_addr,
  input  logic        mem_en,
  input  logic        io_en,
  output logic        hit
);
  localparam int MIN_LOG2 = IS_IO ? 2 : 4;
  localparam int EFF_LOG2 = (SIZE_LOG2 < MIN_LOG2) ? MIN_LOG2 : SIZE_LOG2;
  localparam logic [31:0] ADDR_MASK = 32'hFFFF_FFFF << EFF_LOG2;
  localparam bit HAS_HI = IS_64 && !IS_IO;
  localparam logic [31:0] TYPE_BITS = IS_IO ? 32'h1
                                            : {28'h0, PREFETCH, HAS_HI, 2'b00};

  logic [31:0] base_lo, base_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo <= '0;
      base_hi <= '0;
    end else if (cfg_wr) begin
      for (int b = 0; b < 4; b++) begin
        if (cfg_be[b]) begin
          if (!cfg_hi_sel) base_lo[8*b +: 8] <= cfg_wdata[8*b +: 8] & ADDR_MASK[8*b +: 8];
          else if (HAS_HI) base_hi[8*b +: 8] <= cfg_wdata[8*b +: 8];
        end
      end
    end
  end

  logic [31:0] rd_lo, rd_hi;
  assign rd_lo     = (base_lo & ADDR_MASK) | TYPE_BITS;
  assign rd_hi     = HAS_HI ? base_hi : 32'h0;
  assign cfg_rdata = !IMPL ? 32'h0 : (cfg_hi_sel ? rd_hi : rd_lo);

  logic lo_match, hi_match;
  assign lo_match = ((bus_addr[31:0] ^ base_lo) & ADDR_MASK) == 32'h0;
  assign hi_match = HAS_HI ? (bus_addr[63:32] == base_hi) : (bus_addr[63:32] == 32'h0);
  assign hit = IMPL && (IS_IO ? (io_en && lo_match) : (mem_en && lo_match && hi_match));
endmodule

// File: rtl/bar_decoder_chk.sv
module bar_decoder_chk #(
  parameter bit IS_IO     = 1'b0,
  parameter bit IS_64     = 1'b0,
  parameter bit PREFETCH  = 1'b0,
  parameter int SIZE_LOG2 = 12,
  parameter bit IMPL      = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        cfg_hi_sel,
  input logic [31:0] cfg_rdata,
  input logic        mem_en,
  input logic        io_en,
  input logic        hit
);
  localparam int MIN_LOG2 = IS_IO ? 2 : 4;
  localparam int EFF_LOG2 = (SIZE_LOG2 < MIN_LOG2) ? MIN_LOG2 : SIZE_LOG2;
  localparam logic [31:0] LOW_ADDR = ~(32'hFFFF_FFFF << EFF_LOG2) & (IS_IO ? ~32'h3 : ~32'hF);
  localparam bit HAS_HI = IS_64 && !IS_IO;

  AST_UNIMPL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !IMPL |-> (!hit && cfg_rdata == 32'h0)); // R1
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hi_sel |-> ((cfg_rdata & LOW_ADDR) == 32'h0)); // R2
  AST_MEM_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (IMPL && !IS_IO && !cfg_hi_sel) |-> (cfg_rdata[3:0] == {PREFETCH, HAS_HI, 2'b00})); // R3
  AST_IO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (IMPL && IS_IO && !cfg_hi_sel) |-> (cfg_rdata[1:0] == 2'b01)); // R4
  AST_HI_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_HI && cfg_hi_sel) |-> (cfg_rdata == 32'h0)); // R7
  AST_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (IS_IO ? io_en : mem_en)); // R10
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr ##1 $stable(cfg_hi_sel)) |-> $stable(cfg_rdata)); // R11
endmodule

bind bar_decoder bar_decoder_chk #(
  .IS_IO(IS_IO), .IS_64(IS_64), .PREFETCH(PREFETCH), .SIZE_LOG2(SIZE_LOG2), .IMPL(IMPL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_hi_sel(cfg_hi_sel),
  .cfg_rdata(cfg_rdata), .mem_en(mem_en), .io_en(io_en), .hit(hit)
);

// File: tb/tb_bar_decoder.sv
module tb_bar_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_hi_sel = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [63:0] bus_addr = '0;
  logic        mem_en = 1'b0;
  logic        io_en = 1'b0;
  logic [31:0] rd_v [4];
  logic        hit_v [4];

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] m_lo [4];
  logic [31:0] m_hi [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  bar_decoder #(.IS_IO(0), .IS_64(1), .PREFETCH(1), .SIZE_LOG2(12), .IMPL(1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_hi_sel(cfg_hi_sel), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_v[0]), .bus_addr(bus_addr),
    .mem_en(mem_en), .io_en(io_en), .hit(hit_v[0]));
  bar_decoder #(.IS_IO(0), .IS_64(0), .PREFETCH(0), .SIZE_LOG2(2), .IMPL(1)) dut_m32 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_hi_sel(cfg_hi_sel), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_v[1]), .bus_addr(bus_addr),
    .mem_en(mem_en), .io_en(io_en), .hit(hit_v[1]));
  bar_decoder #(.IS_IO(1), .IS_64(0), .PREFETCH(0), .SIZE_LOG2(5), .IMPL(1)) dut_io (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_hi_sel(cfg_hi_sel), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_v[2]), .bus_addr(bus_addr),
    .mem_en(mem_en), .io_en(io_en), .hit(hit_v[2]));
  bar_decoder #(.IS_IO(0), .IS_64(1), .PREFETCH(0), .SIZE_LOG2(12), .IMPL(0)) dut_none (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_hi_sel(cfg_hi_sel), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_v[3]), .bus_addr(bus_addr),
    .mem_en(mem_en), .io_en(io_en), .hit(hit_v[3]));

  // Per-instance settings taken from the requirements
  function automatic bit p_io(int i);   return i == 2; endfunction
  function automatic bit p_hi(int i);   return i == 0 || i == 3; endfunction
  function automatic bit p_impl(int i); return i != 3; endfunction
  function automatic int p_eff(int i);
    case (i) 0: return 12; 1: return 4; 2: return 5; default: return 12; endcase
  endfunction
  function automatic logic [31:0] p_mask(int i); return 32'hFFFF_FFFF << p_eff(i); endfunction
  function automatic logic [31:0] p_type(int i);
    case (i) 0: return 32'hC; 2: return 32'h1; default: return 32'h0; endcase
  endfunction

  function automatic logic [31:0] exp_rd(int i, logic sel);
    if (!p_impl(i)) return 32'h0;
    if (sel) return p_hi(i) ? m_hi[i] : 32'h0;
    return m_lo[i] | p_type(i);
  endfunction

  function automatic logic exp_hit(int i, logic [63:0] a, logic me, logic ie);
    logic lo_ok, hi_ok;
    if (!p_impl(i)) return 1'b0;
    lo_ok = ((a[31:0] ^ m_lo[i]) & p_mask(i)) == 32'h0;
    hi_ok = p_hi(i) ? (a[63:32] == m_hi[i]) : (a[63:32] == 32'h0);
    if (p_io(i)) return ie && lo_ok;
    return me && lo_ok && hi_ok;
  endfunction

  task automatic check_all(string req);
    #1;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] er;
      logic eh;
      er = exp_rd(i, cfg_hi_sel);
      eh = exp_hit(i, bus_addr, mem_en, io_en);
      vectors += 2;
      if (rd_v[i] !== er) begin
        errors++;
        $display("FAIL %s inst%0d rdata actual=%h expected=%h", req, i, rd_v[i], er);
      end
      if (hit_v[i] !== eh) begin
        errors++;
        $display("FAIL %s inst%0d hit actual=%b expected=%b addr=%h", req, i, hit_v[i], eh, bus_addr);
      end
    end
  endtask

  task automatic cfg_write(logic sel, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_hi_sel = sel; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    for (int i = 0; i < 4; i++) begin
      for (int b = 0; b < 4; b++) begin
        if (be[b]) begin
          if (!sel) m_lo[i][8*b +: 8] = d[8*b +: 8] & p_mask(i)[8*b +: 8];
          else if (p_hi(i)) m_hi[i][8*b +: 8] = d[8*b +: 8];
        end
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0B4E));
    for (int i = 0; i < 4; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_hi_sel = 0; check_all("R5");
    cfg_hi_sel = 1; check_all("R5");
    cfg_hi_sel = 0;

    mem_en = 1; io_en = 1; bus_addr = 64'h0; check_all("R9");
    bus_addr = 64'h3; check_all("R9");
    bus_addr = 64'h10; check_all("R8");
    bus_addr = 64'h1000; check_all("R8");

    cfg_write(0, 4'hF, 32'hFFFF_FFFF); check_all("R2");
    check_all("R3");
    cfg_write(1, 4'hF, 32'hFFFF_FFFF); check_all("R7");
    cfg_hi_sel = 0; check_all("R1");

    cfg_write(0, 4'hF, 32'h0); cfg_write(1, 4'hF, 32'h0);
    cfg_write(0, 4'b0101, 32'hA5A5_A5A5); cfg_hi_sel = 0; check_all("R6");
    cfg_write(1, 4'b1010, 32'h1234_5678); check_all("R6");
    cfg_hi_sel = 0; check_all("R4");

    bus_addr = {m_hi[0], m_lo[0] | 32'h123};
    mem_en = 1; io_en = 0; check_all("R8");
    mem_en = 0; io_en = 1; check_all("R10");
    mem_en = 1; bus_addr[40] = ~bus_addr[40]; check_all("R8");
    bus_addr = {32'hDEAD_0001, m_lo[2] | 32'h1F}; check_all("R8");
    io_en = 0; check_all("R10");

    for (int n = 0; n < 600; n++) begin
      int tgt;
      logic [31:0] lo;
      if (($urandom % 4) == 0) begin
        cfg_write(1'($urandom % 2), 4'($urandom), $urandom);
        cfg_hi_sel = 1'($urandom % 2);
        check_all("R11");
      end else begin
        @(negedge clk);
        tgt = int'($urandom % 3);
        lo = m_lo[tgt] | ($urandom & ~p_mask(tgt));
        if (($urandom % 4) == 0) lo[$urandom % 32] = ~lo[$urandom % 32];
        bus_addr[31:0] = lo;
        case ($urandom % 4)
          0: bus_addr[63:32] = $urandom;
          1: bus_addr[63:32] = 32'h0;
          default: bus_addr[63:32] = m_hi[0];
        endcase
        mem_en = 1'($urandom % 4 != 0);
        io_en = 1'($urandom % 4 != 0);
        cfg_hi_sel = 1'($urandom % 2);
        check_all("R8");
      end
    end
    finish_run();
  end
endmodule